// File: doc/BRIEF.md
# I2C SCL Bit-Period Timebase

This block sets the bit timing for an I2C master. It works in two stages. The first stage is a prescaler: it divides the peripheral clock by one plus a programmable prescale value, and the result is an internal tick. The second stage is a phase counter. It counts those ticks through a low phase and a high phase of the SCL line. Each phase lasts 10 + 4·step ticks, so the two phases together make the fixed 20 + 8·step part of a period.

Between the two phases the block releases SCL. It then waits until the synchronised line reads high before it starts counting the high phase. Slow rise times, internal latency and clock stretching by a target therefore lengthen the period automatically, and no fixed compensation count is needed.

The byte engine uses five outputs from the block:
- a drive-low output for the SCL pad;
- a strobe that marks the start of each low phase;
- a strobe that marks the start of each high phase;
- a mid-low point at which SDA may change;
- a mid-high point at which SDA is sampled.

Top module: `scl_timebase`

## Requirements
- R1: During reset, and while enable is low after reset, scl_drive_low is 0 and none of the four strobes pulses.
- R2: Every low phase holds scl_drive_low high for exactly (10 + 4·step)·(1 + pre) clock cycles, using the step and pre values latched at that period's start.
- R3: After SCL is released, high-phase counting waits for the line. high_start pulses exactly SYNC_STAGES + 1 cycles after scl_in is first seen high, and it never pulses unless the synchronised line was high.
- R4: The next low_start pulse follows high_start by exactly (10 + 4·step)·(1 + pre) cycles.
- R5: sda_change pulses (5 + 2·step)·(1 + pre) cycles after low_start.
- R6: sda_sample pulses (5 + 2·step)·(1 + pre) cycles after high_start.
- R7: div_cfg holds the prescale value pre in bits [PRE_W-1:0]. The 6-bit step field (0 to 63) sits directly above it, in bits [PRE_W+5:PRE_W].
- R8: A change to div_cfg has no effect on the period in progress. It is latched only on the cycle a new low phase begins.
- R9: When enable is deasserted, SCL is released on the next cycle and both counters are reset. When enable is asserted again, low_start pulses on the next cycle and a full low phase follows.
- R10: At most one of low_start, high_start, sda_change and sda_sample is high in any cycle, and each of them pulses for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high; releases SCL and clears the counters when low |
| div_cfg | input | PRE_W+STEP_W | Divider setting: step field above prescale field |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| low_start | output | 1 | One-cycle strobe at the start of each low phase |
| high_start | output | 1 | One-cycle strobe when high-phase counting begins |
| sda_change | output | 1 | One-cycle strobe at mid-low, where SDA may change |
| sda_sample | output | 1 | One-cycle strobe at mid-high, where SDA is sampled |

## Verification
The bench builds the block with its default parameters: a 4-bit prescale field, a 6-bit step field and two synchroniser stages. These make both extremes reachable in a short run: divide-by-one with step 0, and divide-by-sixteen with step 63. The model of the SCL line in the bench releases the line after a chosen rise delay. Long delays stand in for a target that stretches the clock, which exposes the exact wait before high_start. Divider values are changed at random points inside each period, so the bench can check that a new setting applies only from the next low phase.

// File: rtl/scl_timebase_pkg.sv
package scl_timebase_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // Ticks in one phase (low or high) for a given step value.
  function automatic int unsigned half_ticks(int unsigned step);
    return 10 + 4 * step;
  endfunction

  // Tick at which the mid-phase strobe fires.
  function automatic int unsigned mid_ticks(int unsigned step);
    return 5 + 2 * step;
  endfunction

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_high
);

  logic [STAGES-1:0] sh;

  // Idle bus level is high, so the chain resets to 1.
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh[0] <= 1'b1;
          else        sh[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh[i] <= 1'b1;
          else        sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  assign line_high = sh[STAGES-1];

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);

  logic [PRE_W-1:0] cnt;

  assign tick = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || tick)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  // R2: the divider count never passes the latched prescale value
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_timebase_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int STEP_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [PRE_W+STEP_W-1:0] div_cfg,
  input  logic                    line_high,
  input  logic                    tick,
  output logic [PRE_W-1:0]        pre_limit,
  output logic                    pre_clear,
  output logic                    scl_drive_low,
  output logic                    low_start,
  output logic                    high_start,
  output logic                    sda_change,
  output logic                    sda_sample
);

  localparam int CFG_W = PRE_W + STEP_W;
  localparam int CNT_W = STEP_W + 3;

  scl_phase_e         state, state_nx;
  logic [CNT_W-1:0]   cnt;
  logic [CFG_W-1:0]   cfg_q;
  logic [STEP_W-1:0]  step_q;
  logic [CNT_W-1:0]   half_last, mid_last;

  assign step_q    = cfg_q[CFG_W-1:PRE_W];
  assign pre_limit = cfg_q[PRE_W-1:0];
  assign half_last = CNT_W'(half_ticks(32'(step_q)) - 1);
  assign mid_last  = CNT_W'(mid_ticks(32'(step_q)) - 1);

  // Named events, one wire per event
  logic start_req, low_done, line_seen, high_done, enter_low;
  logic low_mid, high_mid;
  assign start_req = (state == PH_IDLE) && enable;
  assign low_done  = (state == PH_LOW)  && tick && (cnt == half_last);
  assign line_seen = (state == PH_WAIT) && line_high;
  assign high_done = (state == PH_HIGH) && tick && (cnt == half_last);
  assign low_mid   = (state == PH_LOW)  && tick && (cnt == mid_last);
  assign high_mid  = (state == PH_HIGH) && tick && (cnt == mid_last);
  assign enter_low = start_req || high_done;

  assign pre_clear = (state == PH_IDLE) || (state == PH_WAIT) || low_done || high_done;
  assign scl_drive_low = (state == PH_LOW);

  always_comb begin
    state_nx = state;
    case (state)
      PH_IDLE: if (start_req) state_nx = PH_LOW;
      PH_LOW:  if (low_done)  state_nx = PH_WAIT;
      PH_WAIT: if (line_seen) state_nx = PH_HIGH;
      PH_HIGH: if (high_done) state_nx = PH_LOW;
      default: state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      cfg_q      <= '0;
      low_start  <= 1'b0;
      high_start <= 1'b0;
      sda_change <= 1'b0;
      sda_sample <= 1'b0;
    end else if (!enable) begin
      state      <= PH_IDLE;
      cnt        <= '0;
      low_start  <= 1'b0;
      high_start <= 1'b0;
      sda_change <= 1'b0;
      sda_sample <= 1'b0;
    end else begin
      state      <= state_nx;
      low_start  <= enter_low;
      high_start <= line_seen;
      sda_change <= low_mid;
      sda_sample <= high_mid;
      if (enter_low) cfg_q <= div_cfg;
      if (enter_low || low_done || line_seen)
        cnt <= '0;
      else if (tick && (state == PH_LOW || state == PH_HIGH))
        cnt <= cnt + 1'b1;
    end
  end

  // R9: a low enable releases SCL on the next cycle
  p_off_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !low_start));

  // R8: the latched divider moves only together with a period start
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !low_start |-> $stable(cfg_q));

  // R3: high-phase counting begins only after the line was seen high
  p_high_after_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    high_start |-> $past(line_high));

  // R10: strobes never coincide
  p_strobe_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_start, high_start, sda_change, sda_sample}));

  // R2: a period start always drives SCL low
  p_low_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    low_start |-> scl_drive_low);

  // R2: the low phase ends on an internal tick or by disable
  p_low_end_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> ($past(tick) || !$past(enable)));

endmodule

// File: rtl/scl_timebase.sv
module scl_timebase #(
  parameter int PRE_W       = 4,
  parameter int STEP_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [PRE_W+STEP_W-1:0] div_cfg,
  input  logic                    scl_in,
  output logic                    scl_drive_low,
  output logic                    low_start,
  output logic                    high_start,
  output logic                    sda_change,
  output logic                    sda_sample
);

  logic             line_high;
  logic             tick;
  logic             pre_clear;
  logic [PRE_W-1:0] pre_limit;

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (scl_in),
    .line_high (line_high)
  );

  scl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (pre_clear),
    .limit (pre_limit),
    .tick  (tick)
  );

  scl_phase_ctrl #(.PRE_W(PRE_W), .STEP_W(STEP_W)) u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .div_cfg       (div_cfg),
    .line_high     (line_high),
    .tick          (tick),
    .pre_limit     (pre_limit),
    .pre_clear     (pre_clear),
    .scl_drive_low (scl_drive_low),
    .low_start     (low_start),
    .high_start    (high_start),
    .sda_change    (sda_change),
    .sda_sample    (sda_sample)
  );

endmodule

// File: tb/test_scl_timebase.sv
module test_scl_timebase;

  localparam int PRE_W  = 4;
  localparam int STEP_W = 6;
  localparam int SYNC   = 2;
  localparam int CFG_W  = PRE_W + STEP_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [CFG_W-1:0] div_cfg = '0;
  logic scl_in = 1'b1;
  logic scl_drive_low, low_start, high_start, sda_change, sda_sample;

  always #10 clk = ~clk;

  scl_timebase #(.PRE_W(PRE_W), .STEP_W(STEP_W), .SYNC_STAGES(SYNC)) i_scl_timebase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_cfg(div_cfg), .scl_in(scl_in),
    .scl_drive_low(scl_drive_low), .low_start(low_start), .high_start(high_start),
    .sda_change(sda_change), .sda_sample(sda_sample)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit timed_out = 0;
  bit track = 0, have_high = 0, prev_low = 0;
  int cur_step = 0, cur_pre = 0;
  int since_low = 0, since_high = 0, low_w = 0, wcnt = 0;
  int rise_cnt = 0, rise_delay = 0, lows_seen = 0;

  // R7: step sits directly above the prescale field
  function automatic logic [CFG_W-1:0] mk_cfg(int step, int pre);
    return CFG_W'((step << PRE_W) | pre);
  endfunction
  function automatic int phase_cyc(int step, int pre);
    return 2 * (5 + 2 * step) * (pre + 1);
  endfunction
  function automatic int mid_cyc(int step, int pre);
    return phase_cyc(step, pre) / 2;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick_cyc();
    @(negedge clk);
    cycles++;
    if (cycles > 190000 && !timed_out) begin
      timed_out = 1;
      check(0, "watchdog", "cycle count", cycles, 190000);
    end
    since_low++; since_high++; wcnt++;
    if (track) begin
      check($countones({low_start, high_start, sda_change, sda_sample}) <= 1,
            "R10", "strobes high together",
            $countones({low_start, high_start, sda_change, sda_sample}), 1);
      if (low_start) begin
        if (have_high)
          check(since_high == phase_cyc(cur_step, cur_pre), "R4", "high phase length",
                since_high, phase_cyc(cur_step, cur_pre));
        cur_step = int'(div_cfg[CFG_W-1:PRE_W]);
        cur_pre  = int'(div_cfg[PRE_W-1:0]);
        since_low = 0; low_w = 0; lows_seen++;
      end
      if (scl_drive_low) low_w++;
      if (prev_low && !scl_drive_low) begin
        check(low_w == phase_cyc(cur_step, cur_pre), "R2", "low phase length",
              low_w, phase_cyc(cur_step, cur_pre));
        wcnt = 0;
      end
      if (sda_change)
        check(since_low == mid_cyc(cur_step, cur_pre), "R5", "sda_change offset",
              since_low, mid_cyc(cur_step, cur_pre));
      if (high_start) begin
        check(wcnt == rise_delay + SYNC + 1, "R3", "wait after release",
              wcnt, rise_delay + SYNC + 1);
        since_high = 0; have_high = 1;
      end
      if (sda_sample)
        check(since_high == mid_cyc(cur_step, cur_pre), "R6", "sda_sample offset",
              since_high, mid_cyc(cur_step, cur_pre));
    end
    // SCL line model: follows the pad, rises rise_delay cycles late
    if (scl_drive_low) begin
      scl_in = 1'b0; rise_cnt = 0;
    end else if (!scl_in) begin
      if (rise_cnt >= rise_delay) scl_in = 1'b1;
      else rise_cnt++;
    end
    prev_low = scl_drive_low;
  endtask

  task automatic run_periods(int n, bit rnd);
    int target = lows_seen + n;
    int change_at = -1;
    while (lows_seen < target && !timed_out) begin
      tick_cyc();
      if (rnd && low_start) begin
        rise_delay = $urandom_range(0, 20);
        change_at = $urandom_range(1, 40);
      end else if (change_at > 0) begin
        change_at--;
        if (change_at == 0)
          div_cfg = mk_cfg($urandom_range(0, 63), $urandom_range(0, 3));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check(scl_drive_low == 1'b0, "R1", "drive_low in reset", scl_drive_low, 0);
    check({low_start, high_start, sda_change, sda_sample} == 4'b0, "R1", "strobes in reset",
          {low_start, high_start, sda_change, sda_sample}, 0);
    rst_n = 1'b1;
    repeat (3) tick_cyc();
    check(scl_drive_low == 1'b0, "R1", "drive_low while disabled", scl_drive_low, 0);
    check({low_start, high_start, sda_change, sda_sample} == 4'b0, "R1", "strobes while disabled",
          {low_start, high_start, sda_change, sda_sample}, 0);

    // Smallest setting, no rise delay
    track = 1; enable = 1'b1; div_cfg = mk_cfg(0, 0); rise_delay = 0;
    run_periods(3, 0);
    // Largest setting (R7: top of both fields)
    div_cfg = mk_cfg(63, 15);
    run_periods(2, 0);
    // Long stretch by the target
    rise_delay = 45; div_cfg = mk_cfg(3, 2);
    run_periods(3, 0);

    // R8: mid-period divider change leaves the running period alone
    rise_delay = 2; div_cfg = mk_cfg(1, 0);
    run_periods(2, 0);
    repeat (7) tick_cyc();
    div_cfg = mk_cfg(20, 3);
    while (scl_drive_low && !timed_out) tick_cyc();
    check(low_w == phase_cyc(1, 0), "R8", "low width after mid-period change",
          low_w, phase_cyc(1, 0));
    run_periods(2, 0);
    check(cur_step == 20 && cur_pre == 3, "R8", "new setting applied next period",
          cur_step * 16 + cur_pre, 20 * 16 + 3);

    // Random settings and rise delays
    run_periods(25, 1);

    // R9: disable mid-low, then re-enable
    while (!(scl_drive_low && since_low > 3) && !timed_out) tick_cyc();
    enable = 1'b0; track = 0; have_high = 0;
    tick_cyc();
    check(scl_drive_low == 1'b0, "R9", "release after disable", scl_drive_low, 0);
    for (int i = 0; i < 8; i++) begin
      tick_cyc();
      check({scl_drive_low, low_start, high_start, sda_change, sda_sample} == 5'b0, "R9",
            "activity while disabled",
            {scl_drive_low, low_start, high_start, sda_change, sda_sample}, 0);
    end
    div_cfg = mk_cfg(2, 1); rise_delay = 0;
    enable = 1'b1; track = 1;
    tick_cyc();
    check(low_start == 1'b1, "R9", "low_start after re-enable", low_start, 1);
    run_periods(2, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule